// File: doc/BRIEF.md
# Frequency Synthesizer Configuration and Lock Timer

This block holds the control side of a frequency synthesizer. Software writes one 32-bit configuration word. The word holds an input pre-divider, a feedback multiplier, an output-band selector and a lock-wait count. From the stored word the block works out the effective divide and multiply ratios. It flags when the synthesizer is switched off, and it flags when the pre-divider is bypassed. It also reports when the configured frequencies fall outside the permitted windows.

Each write starts a countdown measured in slow-clock ticks. The lock indication rises once the programmed number of ticks has elapsed, and it stays high until the next write. The reference input frequency is a parameter. Every frequency check uses integer arithmetic on the current register value, and no analog behaviour is modelled.

Top module: `synth_cfg_ctrl`

## Requirements
- R1: After reset the register reads 0. A write stores bits 26:0 of `wr_data`, bits 31:27 always read as 0, and `rd_data` shows the stored word from the cycle after the write.
- R2: The pre-divider is bits 7:0. A value of 0 gives `eff_div` = 0 and raises `disabled`. A value of 1 gives `eff_div` = 1 and raises `bypass`. Values 2 to 255 give `eff_div` equal to the field, with `bypass` low.
- R3: The multiplier is bits 26:16. A value of 0 gives `eff_mul` = 0 and raises `disabled`. A value of M from 1 to 2047 gives `eff_mul` = M + 1.
- R4: The lock-wait count is bits 13:8. A write with a nonzero count drives `lock` low from the cycle after the write, even if a countdown is still running. The countdown then restarts from the new count.
- R5: While the block is enabled, `lock` is high exactly when the number of `slow_tick` cycles seen since the last write has reached the count. With a count of 0, `lock` is high in the cycle after the write. Once high, `lock` stays high until the next write.
- R6: While `disabled` is high, `lock` is low and ticks do not advance the countdown.
- R7: While the block is enabled, `range_err` is raised when FIN_HZ / div, using integer division, is below 900 000 Hz or above 32 000 000 Hz. It follows the register value in the same cycle.
- R8: The band selector is bits 15:14. Code 00 allows an output of 80 to 160 MHz and code 10 allows 150 to 240 MHz. The output is (FIN_HZ / div) × (mul + 1). Codes 01 and 11 are stored as written and always raise `range_err`. When the block is disabled, only a reserved code raises `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to store |
| rd_data | output | 32 | Stored configuration word |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| lock | output | 1 | Countdown since last write has expired |
| disabled | output | 1 | Divider or multiplier is zero |
| bypass | output | 1 | Divider is 1 |
| range_err | output | 1 | Configuration outside frequency windows or reserved band |
| eff_div | output | 8 | Effective divide ratio |
| eff_mul | output | 12 | Effective multiply ratio |

## Verification
Directed words cover the corners of the decoding:
- an all-ones write, which exercises the reserved bits and a reserved band code;
- a divider of 0 and of 1;
- a multiplier of 0;
- a divided input just outside its window;
- outputs lying in one band but not the other.

The timer is tried in four ways:
- counts of 0 and of nonzero values;
- a rewrite in the middle of a countdown, which tells a restart apart from a continued count;
- extra ticks after lock, which show that lock holds;
- ticks while the block is disabled.

Seeded random words, with small dividers and small multipliers, mix legal and illegal frequency plans. They are checked against a bench model of every output, together with the full tick-by-tick lock timing.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int DIV_W  = 8;
  localparam int LCNT_W = 6;
  localparam int BAND_W = 2;
  localparam int MUL_W  = 11;
  localparam int RSVD_W = 5;
  localparam int EMUL_W = MUL_W + 1;

  // field order is the software-visible layout: div 7:0, lcnt 13:8, band 15:14, mul 26:16
  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [MUL_W-1:0]  mul;
    logic [BAND_W-1:0] band;
    logic [LCNT_W-1:0] lcnt;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  localparam int REG_W = $bits(cfg_t);

  typedef enum logic [BAND_W-1:0] {
    BAND_LOW  = 2'b00,
    BAND_RSV1 = 2'b01,
    BAND_HIGH = 2'b10,
    BAND_RSV3 = 2'b11
  } band_e;

  function automatic logic [63:0] divided_hz(input longint unsigned fin,
                                             input logic [DIV_W-1:0] d);
    if (d == '0) return 64'd0;
    return fin / 64'(d);
  endfunction

  function automatic logic [63:0] synth_hz(input logic [63:0] fdiv,
                                           input logic [MUL_W-1:0] m);
    return fdiv * (64'(m) + 64'd1);
  endfunction

  function automatic logic [EMUL_W-1:0] mul_ratio(input logic [MUL_W-1:0] m);
    if (m == '0) return '0;
    return EMUL_W'(m) + EMUL_W'(1);
  endfunction
endpackage

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic [REG_W-1:0] rd_data
);
  localparam cfg_t WR_MASK = '{rsvd: '0, mul: '1, band: '1, lcnt: '1, div: '1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= cfg_t'(wr_data & REG_W'(WR_MASK));
  end

  assign rd_data = cfg;

  AST_RD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & REG_W'(WR_MASK))); // R1
endmodule

// File: rtl/synth_ratio_decode.sv
module synth_ratio_decode
  import synth_cfg_pkg::*;
(
  input  cfg_t              cfg,
  output logic [DIV_W-1:0]  eff_div,
  output logic [EMUL_W-1:0] eff_mul,
  output logic              disabled,
  output logic              bypass,
  output logic              active
);
  logic div_zero;
  logic mul_zero;

  assign div_zero = (cfg.div == '0);
  assign mul_zero = (cfg.mul == '0);
  assign eff_div  = cfg.div;
  assign eff_mul  = mul_ratio(cfg.mul);
  assign disabled = div_zero | mul_zero;
  assign bypass   = (cfg.div == DIV_W'(1));
  assign active   = !disabled;
endmodule

// File: rtl/synth_range_check.sv
module synth_range_check
  import synth_cfg_pkg::*;
#(
  parameter longint unsigned FIN_HZ  = 64'd18_432_000,
  parameter longint unsigned IN_MIN  = 64'd900_000,
  parameter longint unsigned IN_MAX  = 64'd32_000_000,
  parameter longint unsigned LO_MIN  = 64'd80_000_000,
  parameter longint unsigned LO_MAX  = 64'd160_000_000,
  parameter longint unsigned HI_MIN  = 64'd150_000_000,
  parameter longint unsigned HI_MAX  = 64'd240_000_000
) (
  input  cfg_t cfg,
  input  logic active,
  output logic range_err,
  output logic band_rsvd
);
  logic [63:0] fdiv_hz;
  logic [63:0] fout_hz;
  logic        in_bad;
  logic        out_bad;

  assign fdiv_hz   = divided_hz(FIN_HZ, cfg.div);
  assign fout_hz   = synth_hz(fdiv_hz, cfg.mul);
  assign in_bad    = (fdiv_hz < IN_MIN) || (fdiv_hz > IN_MAX);
  assign band_rsvd = (cfg.band == BAND_RSV1) || (cfg.band == BAND_RSV3);

  always_comb begin
    if (cfg.band == BAND_HIGH) out_bad = (fout_hz < HI_MIN) || (fout_hz > HI_MAX);
    else                       out_bad = (fout_hz < LO_MIN) || (fout_hz > LO_MAX);
  end

  assign range_err = band_rsvd || (active && (in_bad || out_bad));
endmodule

// File: rtl/synth_lock_timer.sv
module synth_lock_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic          active,
  output logic          lock
);
  logic [CW-1:0] remain;
  logic          count_step;
  logic          expired;

  assign expired    = (remain == '0);
  assign count_step = tick && active && !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remain <= '0;
    else if (load)       remain <= load_val;
    else if (count_step) remain <= remain - CW'(1);
  end

  assign lock = active && expired;

  AST_WRITE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val != '0) |=> !lock); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !load |=> lock); // R5
  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(tick) || $past(load))); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !load |=> $stable(remain)); // R6
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter longint unsigned FIN_HZ = 64'd18_432_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              slow_tick,
  output logic              lock,
  output logic              disabled,
  output logic              bypass,
  output logic              range_err,
  output logic [DIV_W-1:0]  eff_div,
  output logic [EMUL_W-1:0] eff_mul
);
  cfg_t cfg_q;
  logic active;
  logic band_rsvd;

  synth_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg_q), .rd_data(rd_data)
  );

  synth_ratio_decode u_dec (
    .cfg(cfg_q), .eff_div(eff_div), .eff_mul(eff_mul),
    .disabled(disabled), .bypass(bypass), .active(active)
  );

  synth_range_check #(.FIN_HZ(FIN_HZ)) u_rng (
    .cfg(cfg_q), .active(active), .range_err(range_err), .band_rsvd(band_rsvd)
  );

  synth_lock_timer #(.CW(LCNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(wr_en),
    .load_val(wr_data[DIV_W +: LCNT_W]), .tick(slow_tick),
    .active(active), .lock(lock)
  );

  AST_RSVD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    band_rsvd |-> range_err); // R8
  AST_BYPASS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (eff_div == DIV_W'(1) && !lock || eff_div == DIV_W'(1))); // R2
  AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |-> !lock); // R6
  AST_OFF_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |-> (eff_div == '0 || eff_mul == '0)); // R3
endmodule

// File: tb/tb_synth_cfg_ctrl.sv
module tb_synth_cfg_ctrl;
  localparam longint unsigned FIN = 64'd18_432_000;

  logic        clk = 0, rst_n = 0, wr_en = 0, slow_tick = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        lock, disabled, bypass, range_err;
  logic [7:0]  eff_div;
  logic [11:0] eff_mul;
  int n_chk = 0, n_fail = 0;

  synth_cfg_ctrl #(.FIN_HZ(FIN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .slow_tick(slow_tick), .lock(lock), .disabled(disabled), .bypass(bypass),
    .range_err(range_err), .eff_div(eff_div), .eff_mul(eff_mul)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_off(input logic [31:0] v);
    return (v[7:0] == 0) || (v[26:16] == 0);
  endfunction

  function automatic bit m_err(input logic [31:0] v);
    longint unsigned d, m, fi, fo;
    if (v[14]) return 1;
    if (m_off(v)) return 0;
    d = longint'(v[7:0]); m = longint'(v[26:16]) + 1;
    fi = FIN / d; fo = fi * m;
    if (fi < 900_000 || fi > 32_000_000) return 1;
    if (v[15]) return !(fo >= 150_000_000 && fo <= 240_000_000);
    return !(fo >= 80_000_000 && fo <= 160_000_000);
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tk();
    slow_tick = 1; @(negedge clk); slow_tick = 0;
  endtask

  task automatic chk_static(input logic [31:0] v);
    logic [31:0] st;
    st = v & 32'h07FF_FFFF;
    chk(rd_data == st, "R1 rd_data", rd_data, st);
    chk(eff_div == v[7:0], "R2 eff_div", eff_div, v[7:0]);
    chk(bypass == (v[7:0] == 1), "R2 bypass", bypass, v[7:0] == 1);
    chk(eff_mul == ((v[26:16] == 0) ? 12'd0 : {1'b0, v[26:16]} + 12'd1), "R3 eff_mul",
        eff_mul, (v[26:16] == 0) ? 0 : v[26:16] + 1);
    chk(disabled == m_off(v), "R2/R3 disabled", disabled, m_off(v));
    chk(range_err == m_err(v), "R7/R8 range_err", range_err, m_err(v));
  endtask

  // write then walk ticks past the count, checking lock after each
  task automatic wr_and_walk(input logic [31:0] v);
    int n;
    wr(v);
    chk_static(v);
    n = int'(v[13:8]);
    for (int k = 0; k <= n + 1; k++) begin
      chk(lock == (!m_off(v) && k >= n), m_off(v) ? "R6 lock off" : "R5 lock timing",
          lock, !m_off(v) && k >= n);
      tk();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data == 0, "R1 reset", rd_data, 0);
    chk(lock == 0, "R6 reset lock", lock, 0);
    chk(disabled == 1, "R2 reset disabled", disabled, 1);

    // R1 reserved bits, R8 reserved band code
    wr(32'hFFFF_FFFF); chk_static(32'hFFFF_FFFF);
    chk(range_err == 1, "R8 reserved band", range_err, 1);
    // legal high-band plan: div 4, mul 38, lcnt 5
    wr_and_walk({5'd0, 11'd38, 2'b10, 6'd5, 8'd4});
    // same plan in low band -> out of window
    wr_and_walk({5'd0, 11'd38, 2'b00, 6'd0, 8'd4});
    // bypass, mul 4 -> 92.16 MHz low band legal
    wr_and_walk({5'd0, 11'd4, 2'b00, 6'd3, 8'd1});
    // divided input too low: div 32
    wr_and_walk({5'd0, 11'd200, 2'b10, 6'd2, 8'd32});
    // multiplier 0 and divider 0
    wr_and_walk({5'd0, 11'd0, 2'b00, 6'd0, 8'd4});
    wr_and_walk({5'd0, 11'd38, 2'b01, 6'd0, 8'd0});
    chk(range_err == 1, "R8 reserved while disabled", range_err, 1);

    // R4 restart mid-countdown
    wr({5'd0, 11'd38, 2'b10, 6'd6, 8'd4});
    tk(); tk(); tk();
    chk(lock == 0, "R4 mid count", lock, 0);
    wr({5'd0, 11'd38, 2'b10, 6'd2, 8'd4});
    chk(lock == 0, "R4 restart", lock, 0);
    tk();
    chk(lock == 0, "R4 restart one tick", lock, 0);
    tk();
    chk(lock == 1, "R4 restart done", lock, 1);
    repeat (4) tk();
    chk(lock == 1, "R5 holds", lock, 1);
    wr({5'd0, 11'd38, 2'b10, 6'd1, 8'd4});
    chk(lock == 0, "R4 write drops lock", lock, 0);

    // R6 ticks while disabled do not count
    wr({5'd0, 11'd0, 2'b00, 6'd2, 8'd4});
    repeat (5) tk();
    chk(lock == 0, "R6 disabled", lock, 0);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = $urandom;
      v[7:0]   = 8'($urandom_range(0, 24));
      v[26:16] = 11'($urandom_range(0, 60));
      v[13:8]  = 6'($urandom_range(0, 9));
      wr_and_walk(v);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule